// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is the eight-bit control and status register that sits between two 16-bit timers, two active-low external interrupt pins and the interrupt controller of a small microcontroller. It holds the run enables for both timers and the trigger-type selection for both external pins. It also holds four pending flags, one per interrupt source. Software reaches it through a byte-wide special-function-register port at address 0x88 and through a single-bit port that covers bit addresses 0x88 to 0x8F.

Each pending flag can change from three places. Hardware sets it on a timer wrap strobe or an external request. Software writes it. The interrupt controller clears it with an acknowledge strobe. Fixed priorities decide which one wins when they meet in the same cycle. Each external pin can request on a falling edge or for as long as it stays low. The pins arrive already synchronized.

Top module: `tcon_reg`

## Requirements
- R1: A synchronous reset clears all eight register bits, so every run output, every pending output and the read value are 0 on the first cycle after reset.
- R2: A byte write to address 0x88 loads the register. Bit 7 is the timer-1 flag, bit 6 timer-1 run, bit 5 the timer-0 flag, bit 4 timer-0 run, bit 3 the ext-1 flag, bit 2 the ext-1 type, bit 1 the ext-0 flag and bit 0 the ext-0 type. A read at 0x88 returns the register, a read at any other address returns 0, and a byte write to any other address changes nothing.
- R3: A single-bit write to bit address 0x88+n (n = 0..7) loads only bit n. A single-bit write to an address outside 0x88..0x8F changes nothing.
- R4: `tmr_run[0]` equals bit 4 and `tmr_run[1]` equals bit 6.
- R5: A strobe on `tmr_ovf[k]` sets the timer-k flag at that clock edge.
- R6: When a type bit is 1 (edge mode), a 1-to-0 change of the pin between two consecutive clocks sets the ext flag once. Holding the pin low does not set it again after a clear. The previous-pin register resets to 1.
- R7: When a type bit is 0 (level mode), the ext flag loads the inverted pin at every edge. Software writes and acknowledges to that flag have no effect.
- R8: `intr_ack` and `irq_pend` share one index order: 0 = ext-0, 1 = timer-0, 2 = ext-1, 3 = timer-1. An acknowledge clears that flag.
- R9: A hardware set beats a software write and an acknowledge to the same flag in the same cycle.
- R10: A software write (byte or bit) beats an acknowledge to the same flag in the same cycle.
- R11: When a byte write and a single-bit write both hit in the same cycle, the single-bit value wins for its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Byte port address, used for read and write |
| sfr_we | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Register value when `sfr_addr` is 0x88, else 0 |
| bit_addr | input | 8 | Single-bit port address |
| bit_we | input | 1 | Single-bit write strobe |
| bit_wval | input | 1 | Single-bit write value |
| tmr_ovf | input | 2 | Timer wrap strobes, index = timer |
| xint_n | input | 2 | Synchronized active-low external pins, index = channel |
| intr_ack | input | 4 | Acknowledge strobes (0 ext-0, 1 timer-0, 2 ext-1, 3 timer-1) |
| tmr_run | output | 2 | Timer run enables |
| irq_pend | output | 4 | Pending flags, same order as `intr_ack` |

## Verification
Every one of the 256 byte values is written, then overwritten at a wrong address. This separates correct field placement from leakage through the address decode, and the level-mode forcing of the ext flags is exercised on the same writes. Single-bit writes sweep 24 addresses with both values, which shows whether a write touches only its own bit and whether addresses outside the window are rejected. All eight combinations of set, write and acknowledge are run on the timer flags, and each result identifies which priority decided it. A long pseudo-random run follows, with the pins, strobes and writes all varying. Short directed sequences then show the single set in edge mode and how an acknowledge fails to clear a flag while the pin is still low in level mode.

// File: rtl/tcon_pkg.sv
package tcon_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned N_FLAGS = 4;
  localparam int unsigned N_CH    = 2;

  // Flag index (ext0, tmr0, ext1, tmr1) to register bit position.
  function automatic int unsigned flag_pos(input int unsigned idx);
    return 1 + 2 * (idx / 2) + 4 * (idx % 2);
  endfunction

  // Type bit of external channel c; run bit of timer c.
  function automatic int unsigned type_pos(input int unsigned ch);
    return 2 * ch;
  endfunction

  function automatic int unsigned run_pos(input int unsigned ch);
    return 4 + 2 * ch;
  endfunction
endpackage

// File: rtl/tcon_fall_det.sv
module tcon_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_n;
  end

  assign fall = prev_q & ~pin_n;

  // R6: a falling edge yields a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tcon_flag_bit.sv
module tcon_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic wr_en,
  input  logic wr_val,
  input  logic ack,
  input  logic force_en,
  input  logic force_val,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (force_en) q <= force_val;
    else if (hw_set)   q <= 1'b1;
    else if (wr_en)    q <= wr_val;
    else if (ack)      q <= 1'b0;
  end

  // R7: level mode tracks the forced value regardless of writes/acks
  a_r7_level_track: assert property (@(posedge clk) disable iff (rst)
    force_en |=> q == $past(force_val));
  // R9: hardware set is never lost
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hw_set && !force_en) |=> q);
  // R10: software write beats acknowledge
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hw_set && !force_en) |=> q == $past(wr_val));
  // R8: a lone acknowledge clears
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !wr_en && !hw_set && !force_en) |=> !q);
endmodule

// File: rtl/tcon_reg.sv
module tcon_reg #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h88,
  parameter logic [7:0]  BIT_BASE = 8'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_we,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_we,
  input  logic              bit_wval,
  input  logic [1:0]        tmr_ovf,
  input  logic [1:0]        xint_n,
  input  logic [3:0]        intr_ack,
  output logic [1:0]        tmr_run,
  output logic [3:0]        irq_pend
);
  import tcon_pkg::*;

  localparam int unsigned SEL_W = $clog2(REG_W);

  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] wr_mask;
  logic [REG_W-1:0] wr_vals;
  logic [N_CH-1:0]  fall;
  logic             byte_hit;
  logic             bit_hit;
  logic [SEL_W-1:0] bit_sel;

  assign byte_hit = sfr_we && (sfr_addr == ADDR_W'(REG_ADDR));
  assign bit_hit  = bit_we &&
                    (bit_addr[ADDR_W-1:SEL_W] == ADDR_W'(BIT_BASE) >> SEL_W);
  assign bit_sel  = bit_addr[SEL_W-1:0];

  // Merge byte and single-bit writes; the single bit overrides its lane.
  always_comb begin
    wr_mask = byte_hit ? '1 : '0;
    wr_vals = sfr_wdata;
    if (bit_hit) begin
      wr_mask[bit_sel] = 1'b1;
      wr_vals[bit_sel] = bit_wval;
    end
  end

  genvar c, i;
  generate
    for (c = 0; c < N_CH; c++) begin : g_ch
      localparam int unsigned TP = type_pos(c);
      localparam int unsigned RP = run_pos(c);

      tcon_fall_det u_fall (
        .clk   (clk),
        .rst   (rst),
        .pin_n (xint_n[c]),
        .fall  (fall[c])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          ctl_q[TP] <= 1'b0;
          ctl_q[RP] <= 1'b0;
        end else begin
          if (wr_mask[TP]) ctl_q[TP] <= wr_vals[TP];
          if (wr_mask[RP]) ctl_q[RP] <= wr_vals[RP];
        end
      end

      assign tmr_run[c] = ctl_q[RP];
    end

    for (i = 0; i < N_FLAGS; i++) begin : g_flag
      localparam int unsigned FP = flag_pos(i);
      localparam int unsigned CH = i / 2;
      logic hw_set, force_en, force_val;

      if (i % 2 == 0) begin : g_ext
        assign hw_set    = ctl_q[type_pos(CH)] & fall[CH];
        assign force_en  = ~ctl_q[type_pos(CH)];
        assign force_val = ~xint_n[CH];
      end else begin : g_tmr
        assign hw_set    = tmr_ovf[CH];
        assign force_en  = 1'b0;
        assign force_val = 1'b0;
      end

      tcon_flag_bit u_flag (
        .clk       (clk),
        .rst       (rst),
        .hw_set    (hw_set),
        .wr_en     (wr_mask[FP]),
        .wr_val    (wr_vals[FP]),
        .ack       (intr_ack[i]),
        .force_en  (force_en),
        .force_val (force_val),
        .q         (ctl_q[FP])
      );

      assign irq_pend[i] = ctl_q[FP];
    end
  endgenerate

  assign sfr_rdata = (sfr_addr == ADDR_W'(REG_ADDR)) ? ctl_q : '0;

  // R1: reset leaves everything clear
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ctl_q == '0));
  // R5: a timer strobe always shows up as pending
  a_r5_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf[0] |=> irq_pend[1]);
  a_r5_ovf1_sets: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf[1] |=> irq_pend[3]);
  // R2: a read at the register address agrees with the pending outputs
  a_r2_read_match: assert property (@(posedge clk) disable iff (rst)
    (sfr_addr == ADDR_W'(REG_ADDR)) |->
      (sfr_rdata[7] == irq_pend[3] && sfr_rdata[1] == irq_pend[0]));
  // R6: edge mode with no events keeps the ext-0 flag stable
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[0] && !fall[0] && !wr_mask[1] && !intr_ack[0]) |=> $stable(irq_pend[0]));
endmodule

// File: tb/tcon_reg_tb.sv
module tcon_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata, bit_addr;
  logic       sfr_we, bit_we, bit_wval;
  logic [1:0] tmr_ovf, xint_n, tmr_run;
  logic [3:0] intr_ack, irq_pend;

  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;
  logic [7:0] exp_q;
  logic [1:0] exp_prev;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcon_reg u_dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .bit_addr(bit_addr),
    .bit_we(bit_we), .bit_wval(bit_wval), .tmr_ovf(tmr_ovf),
    .xint_n(xint_n), .intr_ack(intr_ack), .tmr_run(tmr_run),
    .irq_pend(irq_pend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sfr_we = 0; bit_we = 0; tmr_ovf = 0; intr_ack = 0;
  endtask

  // Reference model from the requirements: ack < write < single bit < set < level.
  function automatic logic [7:0] model_next(input logic [7:0] cur, input logic [1:0] prv);
    logic [7:0] n;
    int fp[4] = '{1, 5, 3, 7};
    n = cur;
    for (int k = 0; k < 4; k++) if (intr_ack[k]) n[fp[k]] = 1'b0;
    if (sfr_we && sfr_addr == 8'h88) n = sfr_wdata;
    if (bit_we && bit_addr[7:3] == 5'b10001) n[bit_addr[2:0]] = bit_wval;
    if (tmr_ovf[0]) n[5] = 1'b1;
    if (tmr_ovf[1]) n[7] = 1'b1;
    for (int ch = 0; ch < 2; ch++) begin
      if (cur[2*ch]) begin
        if (prv[ch] && !xint_n[ch]) n[1+2*ch] = 1'b1;
      end else begin
        n[1+2*ch] = ~xint_n[ch];
      end
    end
    return n;
  endfunction

  task automatic step(input string tag);
    @(posedge clk);
    exp_q    = model_next(exp_q, exp_prev);
    exp_prev = xint_n;
    @(negedge clk);
    chk(tag, {18'd0, sfr_rdata, tmr_run, irq_pend},
        {18'd0, (sfr_addr == 8'h88) ? exp_q : 8'h00, exp_q[6], exp_q[4],
         exp_q[7], exp_q[3], exp_q[5], exp_q[1]});
    idle();
  endtask

  task automatic bitw(input logic [7:0] a, input logic v);
    bit_we = 1; bit_addr = a; bit_wval = v;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1; sfr_addr = 8'h88; sfr_wdata = 0; bit_addr = 0; bit_wval = 0; xint_n = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0; exp_q = 0; exp_prev = 2'b11;
    chk("R1", {sfr_rdata, tmr_run, irq_pend}, 14'd0);

    // R2: every byte value, then a write to a wrong address
    for (int v = 0; v < 256; v++) begin
      sfr_we = 1; sfr_addr = 8'h88; sfr_wdata = v[7:0]; step("R2");
      sfr_we = 1; sfr_addr = 8'h98; sfr_wdata = ~v[7:0]; step("R2");
      sfr_addr = 8'h88;
    end
    sfr_we = 1; sfr_wdata = 8'h00; step("R2");

    // R3: single-bit sweep inside and outside the window
    for (int a = 8'h80; a < 8'h98; a++)
      for (int v = 1; v >= 0; v--) begin
        bitw(a[7:0], v[0]); step("R3");
      end

    // R11: byte and bit write together
    for (int b = 0; b < 8; b++) begin
      sfr_we = 1; sfr_wdata = 8'h55; bitw(8'h88 + b[7:0], ~sfr_wdata[b]); step("R11");
    end

    // R9 / R10 / R8: exhaustive set/ack/write on the timer flags
    for (int t = 0; t < 2; t++)
      for (int cmb = 0; cmb < 8; cmb++) begin
        bitw(8'h8D + 8'(2*t), 1'b1); step("R8");
        tmr_ovf[t] = cmb[0]; intr_ack[1+2*t] = cmb[1];
        if (cmb[2]) bitw(8'h8D + 8'(2*t), 1'b0);
        if (cmb[0] && (cmb[1] || cmb[2]))  step("R9");
        else if (cmb[2] && cmb[1])         step("R10");
        else                               step("R8");
      end

    // Pseudo-random mix
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sfr_we    = (lfsr[3:0] == 0);
      sfr_addr  = lfsr[8] ? 8'h88 : 8'h89;
      sfr_wdata = lfsr[15:8];
      bit_we    = (lfsr[7:5] == 0);
      bit_addr  = {4'h8, lfsr[12:9]};
      bit_wval  = lfsr[13];
      tmr_ovf   = lfsr[1:0] & {2{lfsr[14]}};
      intr_ack  = lfsr[11:8] & {4{lfsr[4]}};
      if (lfsr[2] && lfsr[6]) xint_n = xint_n ^ lfsr[1:0];
      step("R5");
    end

    // Directed corners with literal expectations
    sfr_addr = 8'h88; xint_n = 2'b11;
    sfr_we = 1; sfr_wdata = 8'h00; step("R1");
    bitw(8'h88, 1'b1); step("R6");
    xint_n[0] = 0; step("R6");
    chk("R6", irq_pend[0], 1);
    intr_ack[0] = 1; step("R8");
    chk("R8", irq_pend[0], 0);
    repeat (3) step("R6");
    chk("R6", irq_pend[0], 0);
    xint_n[1] = 0; step("R7");
    chk("R7", irq_pend[2], 1);
    intr_ack[2] = 1; step("R7");
    chk("R7", irq_pend[2], 1);
    xint_n[1] = 1; step("R7");
    chk("R7", irq_pend[2], 0);
    bitw(8'h8B, 1'b1); step("R7");
    chk("R7", irq_pend[2], 0);
    bitw(8'h8C, 1'b1); step("R4");
    chk("R4", tmr_run, 2'b01);
    tmr_ovf[1] = 1; step("R5");
    chk("R5", irq_pend[3], 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule